// File: doc/BRIEF.md
# Load-Use and Branch Interlock Controller

This block decides, every cycle, whether the instruction sitting in the Decode stage of a five-stage in-order pipeline may advance. It compares the source registers that the Decode instruction actually reads against the destinations of the two instructions ahead of it. A stall is needed when the value cannot yet be forwarded. The architecture has no load delay slot, so a consumer placed right after a load must be held by hardware. Branches resolve their comparison in Decode, so their operands are needed one stage earlier than an ALU's.

While it stalls, the block drops the write enables of the program counter and of the Fetch/Decode instruction register. The held instruction is therefore presented again and re-evaluated on the next cycle. At the same time the block loads an empty slot into the Decode/Execute control register in place of the held instruction. The block owns the control side of the Decode/Execute and Execute/Memory pipeline registers (destination, write flag, load flag, store flag, valid). This keeps hazard flags aligned with their instructions, and a held instruction is never injected twice. Forwarding selection and next-PC computation are left to neighbouring logic.

Top module: `hz_interlock`

## Requirements
- R1: While `rst` is high, every Execute and Memory control output is cleared on the next clock edge, including both valid flags.
- R2: A load-use stall is raised in the same cycle when all of the following hold: Decode is valid, and Execute holds a load (`ex_load` and `ex_regwr` both 1) whose nonzero `ex_rd` equals a Decode source whose use flag is 1.
- R3: In a stalled cycle, the following edge loads an empty slot into Execute: `ex_valid`, `ex_regwr`, `ex_load`, `ex_memwr` and `ex_rd` all become 0.
- R4: No stall is raised for any of these cases: a source whose use flag is 0; a destination of register 0; a non-branch reading the result of an ALU instruction in Execute; a non-branch reading a load that has reached Memory.
- R5: With branch resolution in Decode (`BR_IN_DECODE`=1), a valid branch stalls when Execute writes (`ex_regwr`=1) a nonzero register equal to a used branch source.
- R6: A valid branch also stalls when Memory holds a load (`mem_load` and `mem_regwr` both 1) writing a nonzero register equal to a used branch source. It does not stall on an ALU result in Memory.
- R7: Without a stall, the edge copies the Decode fields into Execute with `ex_valid`=1. Every edge copies Execute into Memory unchanged, bubbles included.
- R8: The stall persists until the operand is reachable. A load followed directly by a dependent ALU instruction is held exactly 1 cycle. A load followed directly by a dependent branch is held exactly 2 cycles. An ALU write followed directly by a dependent branch is held exactly 1 cycle.
- R9: With `dec_valid`=0 no stall is raised, and the next edge loads an empty slot into Execute.
- R10: `pc_we` and `ifid_we` are both the inverse of `stall` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_rs | input | AW | First source register of Decode |
| dec_rt | input | AW | Second source register of Decode |
| dec_use_rs | input | 1 | First source is read |
| dec_use_rt | input | 1 | Second source is read |
| dec_branch | input | 1 | Decode instruction is a branch compared in Decode |
| dec_rd | input | AW | Destination register of Decode |
| dec_regwr | input | 1 | Decode instruction writes a register |
| dec_load | input | 1 | Decode instruction is a load |
| dec_memwr | input | 1 | Decode instruction writes memory |
| stall | output | 1 | Decode must wait this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/Decode instruction register write enable |
| ex_valid | output | 1 | Execute slot holds a real instruction |
| ex_rd | output | AW | Execute destination |
| ex_regwr | output | 1 | Execute register-write flag |
| ex_load | output | 1 | Execute load flag |
| ex_memwr | output | 1 | Execute memory-write flag |
| mem_valid | output | 1 | Memory slot holds a real instruction |
| mem_rd | output | AW | Memory destination |
| mem_regwr | output | 1 | Memory register-write flag |
| mem_load | output | 1 | Memory load flag |
| mem_memwr | output | 1 | Memory memory-write flag |

## Verification
The bench targets the exact stall lengths: a load feeding a branch must be held two cycles, not one. A controller that only looked at Execute would release the branch while the load was still in Memory, and the branch would compare stale data. Bubbles are checked for cleared write flags and destination, since a bubble that kept the held instruction's flags would retire it twice. The bench also feeds register 0 destinations, unused sources whose numbers still match, and ALU results sitting in Memory. A careless comparator would stall on these for no reason and cost throughput. A long run with a narrow register range then collides sources and destinations densely.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    HZ_NONE     = 2'd0,
    HZ_LOAD_USE = 2'd1,
    HZ_BR_EX    = 2'd2,
    HZ_BR_MEM   = 2'd3
  } hz_cause_t;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          use_src,
  input  logic [AW-1:0] dst,
  input  logic          dst_live,
  output logic          hit
);
  // A producer only matters when it really writes a nonzero register.
  logic dst_nonzero;
  assign dst_nonzero = (dst != '0);
  assign hit = use_src && dst_live && dst_nonzero && (src == dst);
endmodule

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
#(
  parameter int AW           = 5,
  parameter int NSRC         = 2,
  parameter bit BR_IN_DECODE = 1'b1
) (
  input  logic                     dec_valid,
  input  logic [NSRC-1:0][AW-1:0]  src,
  input  logic [NSRC-1:0]          use_src,
  input  logic                     dec_branch,
  input  logic [AW-1:0]            ex_rd,
  input  logic                     ex_regwr,
  input  logic                     ex_load,
  input  logic [AW-1:0]            mem_rd,
  input  logic                     mem_regwr,
  input  logic                     mem_load,
  output logic                     stall,
  output hz_cause_t                cause
);
  logic [NSRC-1:0] hit_ex;
  logic [NSRC-1:0] hit_mem_ld;
  logic            mem_ld_live;

  assign mem_ld_live = mem_regwr && mem_load;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_match #(.AW(AW)) u_ex (
      .src(src[g]), .use_src(use_src[g]),
      .dst(ex_rd), .dst_live(ex_regwr), .hit(hit_ex[g])
    );
    hz_src_match #(.AW(AW)) u_mem (
      .src(src[g]), .use_src(use_src[g]),
      .dst(mem_rd), .dst_live(mem_ld_live), .hit(hit_mem_ld[g])
    );
  end

  logic load_use;
  logic br_ex;
  logic br_mem;

  // Load in Execute: its data appears only at the end of Memory.
  assign load_use = dec_valid && ex_load && (|hit_ex);

  if (BR_IN_DECODE) begin : g_br_dec
    // Early comparison needs any Execute result and a Memory load result.
    assign br_ex  = dec_valid && dec_branch && (|hit_ex);
    assign br_mem = dec_valid && dec_branch && (|hit_mem_ld);
  end else begin : g_br_late
    assign br_ex  = 1'b0;
    assign br_mem = 1'b0;
  end

  always_comb begin
    if (load_use)    cause = HZ_LOAD_USE;
    else if (br_ex)  cause = HZ_BR_EX;
    else if (br_mem) cause = HZ_BR_MEM;
    else             cause = HZ_NONE;
  end

  assign stall = (cause != HZ_NONE);
endmodule

// File: rtl/hz_ctrl_pipe.sv
module hz_ctrl_pipe #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bubble,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_rd,
  input  logic          dec_regwr,
  input  logic          dec_load,
  input  logic          dec_memwr,
  output logic          ex_valid,
  output logic [AW-1:0] ex_rd,
  output logic          ex_regwr,
  output logic          ex_load,
  output logic          ex_memwr,
  output logic          mem_valid,
  output logic [AW-1:0] mem_rd,
  output logic          mem_regwr,
  output logic          mem_load,
  output logic          mem_memwr
);
  logic take;
  assign take = dec_valid && !bubble;

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid  <= 1'b0;
      ex_rd     <= '0;
      ex_regwr  <= 1'b0;
      ex_load   <= 1'b0;
      ex_memwr  <= 1'b0;
      mem_valid <= 1'b0;
      mem_rd    <= '0;
      mem_regwr <= 1'b0;
      mem_load  <= 1'b0;
      mem_memwr <= 1'b0;
    end else begin
      mem_valid <= ex_valid;
      mem_rd    <= ex_rd;
      mem_regwr <= ex_regwr;
      mem_load  <= ex_load;
      mem_memwr <= ex_memwr;
      ex_valid  <= take;
      ex_rd     <= take ? dec_rd    : '0;
      ex_regwr  <= take ? dec_regwr : 1'b0;
      ex_load   <= take ? dec_load  : 1'b0;
      ex_memwr  <= take ? dec_memwr : 1'b0;
    end
  end

  a_r3_bubble_empty: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (!ex_valid && !ex_regwr && !ex_load && !ex_memwr && ex_rd == '0));

  a_r7_mem_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_valid == $past(ex_valid) && mem_rd == $past(ex_rd)
              && mem_regwr == $past(ex_regwr) && mem_load == $past(ex_load)));

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!ex_valid && !mem_valid && !ex_regwr && !mem_regwr));
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int AW           = 5,
  parameter bit BR_IN_DECODE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [AW-1:0] dec_rs,
  input  logic [AW-1:0] dec_rt,
  input  logic          dec_use_rs,
  input  logic          dec_use_rt,
  input  logic          dec_branch,
  input  logic [AW-1:0] dec_rd,
  input  logic          dec_regwr,
  input  logic          dec_load,
  input  logic          dec_memwr,
  output logic          stall,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          ex_valid,
  output logic [AW-1:0] ex_rd,
  output logic          ex_regwr,
  output logic          ex_load,
  output logic          ex_memwr,
  output logic          mem_valid,
  output logic [AW-1:0] mem_rd,
  output logic          mem_regwr,
  output logic          mem_load,
  output logic          mem_memwr
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] srcs;
  logic [NSRC-1:0]         uses;
  hz_cause_t               cause;

  assign srcs = {dec_rt, dec_rs};
  assign uses = {dec_use_rt, dec_use_rs};

  hz_detect #(.AW(AW), .NSRC(NSRC), .BR_IN_DECODE(BR_IN_DECODE)) u_det (
    .dec_valid(dec_valid), .src(srcs), .use_src(uses), .dec_branch(dec_branch),
    .ex_rd(ex_rd), .ex_regwr(ex_regwr), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_regwr(mem_regwr), .mem_load(mem_load),
    .stall(stall), .cause(cause)
  );

  // Freeze fetch while the Decode instruction is held.
  assign pc_we   = !stall;
  assign ifid_we = !stall;

  hz_ctrl_pipe #(.AW(AW)) u_pipe (
    .clk(clk), .rst(rst), .bubble(stall),
    .dec_valid(dec_valid), .dec_rd(dec_rd), .dec_regwr(dec_regwr),
    .dec_load(dec_load), .dec_memwr(dec_memwr),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_regwr(ex_regwr),
    .ex_load(ex_load), .ex_memwr(ex_memwr),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_regwr(mem_regwr),
    .mem_load(mem_load), .mem_memwr(mem_memwr)
  );

  a_r2_load_use: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && ex_load && ex_regwr && ex_rd != '0
     && ((dec_use_rs && dec_rs == ex_rd) || (dec_use_rt && dec_rt == ex_rd)))
    |-> stall);

  a_r5_branch_ex: assert property (@(posedge clk) disable iff (rst)
    (BR_IN_DECODE && dec_valid && dec_branch && ex_regwr && ex_rd != '0
     && ((dec_use_rs && dec_rs == ex_rd) || (dec_use_rt && dec_rt == ex_rd)))
    |-> stall);

  a_r6_mem_alu_quiet: assert property (@(posedge clk) disable iff (rst)
    (!mem_load && !ex_regwr) |-> !stall);

  a_r9_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !stall);

  a_r4_zero_src_quiet: assert property (@(posedge clk) disable iff (rst)
    ((!dec_use_rs || dec_rs == '0) && (!dec_use_rt || dec_rt == '0)) |-> !stall);

  a_r10_fetch_frozen: assert property (@(posedge clk) disable iff (rst)
    stall |-> (!pc_we && !ifid_we && $onehot0({pc_we, stall})));
endmodule

// File: tb/sim_hz_interlock.sv
module sim_hz_interlock;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dv = 1'b0, urs = 1'b0, urt = 1'b0, br = 1'b0, rw = 1'b0, ld = 1'b0, mw = 1'b0;
  logic [AW-1:0] rs = '0, rt = '0, rd = '0;
  logic stall, pc_we, ifid_we;
  logic ex_valid, ex_regwr, ex_load, ex_memwr;
  logic mem_valid, mem_regwr, mem_load, mem_memwr;
  logic [AW-1:0] ex_rd, mem_rd;

  always #4 clk = ~clk;

  hz_interlock #(.AW(AW), .BR_IN_DECODE(1'b1)) u0 (
    .clk(clk), .rst(rst), .dec_valid(dv), .dec_rs(rs), .dec_rt(rt),
    .dec_use_rs(urs), .dec_use_rt(urt), .dec_branch(br), .dec_rd(rd),
    .dec_regwr(rw), .dec_load(ld), .dec_memwr(mw),
    .stall(stall), .pc_we(pc_we), .ifid_we(ifid_we),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_regwr(ex_regwr), .ex_load(ex_load),
    .ex_memwr(ex_memwr), .mem_valid(mem_valid), .mem_rd(mem_rd),
    .mem_regwr(mem_regwr), .mem_load(mem_load), .mem_memwr(mem_memwr)
  );

  int checks = 0, fails = 0, cyc = 0;
  // behavioural model of the two downstream slots
  bit e_v, e_rw, e_ld, e_mw, m_v, m_rw, m_ld, m_mw;
  int e_rd, m_rd;
  string reg_tag = "R1";
  bit last_stall;

  task automatic chk(bit ok, string tag, string what, longint got, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog got=%0d exp=0", cyc);
      summary();
    end
  end

  function automatic bit uses_reg(int r);
    return r != 0 && ((urs && int'(rs) == r) || (urt && int'(rt) == r));
  endfunction

  task automatic dec(bit v, int s, int t, bit us, bit ut, bit b, int d, bit w, bit l, bit m);
    dv = v; rs = AW'(s); rt = AW'(t); urs = us; urt = ut; br = b;
    rd = AW'(d); rw = w; ld = l; mw = m;
  endtask

  task automatic step();
    bit lu, bex, bmem, exp_st;
    string tag;
    longint got_r, exp_r;
    #1;
    got_r = {ex_valid, ex_rd, ex_regwr, ex_load, ex_memwr, mem_valid, mem_rd, mem_regwr, mem_load, mem_memwr};
    exp_r = {e_v, AW'(e_rd), e_rw, e_ld, e_mw, m_v, AW'(m_rd), m_rw, m_ld, m_mw};
    chk(got_r == exp_r, reg_tag, "pipe regs", got_r, exp_r);
    lu   = dv && e_ld && e_rw && uses_reg(e_rd);
    bex  = dv && br && e_rw && uses_reg(e_rd);
    bmem = dv && br && m_rw && m_ld && uses_reg(m_rd);
    exp_st = lu || bex || bmem;
    if (lu) tag = "R2"; else if (bex) tag = "R5"; else if (bmem) tag = "R6";
    else if (!dv) tag = "R9"; else tag = "R4";
    chk(stall == exp_st, tag, "stall", stall, exp_st);
    chk(pc_we == !exp_st && ifid_we == !exp_st, "R10", "pc_we/ifid_we",
        {pc_we, ifid_we}, {!exp_st, !exp_st});
    last_stall = stall;
    @(posedge clk);
    m_v = e_v; m_rd = e_rd; m_rw = e_rw; m_ld = e_ld; m_mw = e_mw;
    if (dv && !exp_st) begin
      e_v = 1; e_rd = int'(rd); e_rw = rw; e_ld = ld; e_mw = mw;
    end else begin
      e_v = 0; e_rd = 0; e_rw = 0; e_ld = 0; e_mw = 0;
    end
    reg_tag = exp_st ? "R3" : (!dv ? "R9" : "R7");
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin dec(0,0,0,0,0,0,0,0,0,0); step(); end
  endtask

  // Hold the current Decode instruction until released; report stall count.
  task automatic hold_count(output int n);
    n = 0;
    do begin step(); n += int'(last_stall); end while (last_stall && n < 6);
  endtask

  initial begin
    int n;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    step();                                            // R1 reset state
    idle(1);
    // R8 load then dependent ALU: one cycle
    dec(1,0,0,0,0,0,2,1,1,0); step();
    dec(1,2,1,1,1,0,3,1,0,0); hold_count(n);
    chk(n == 1, "R8", "load->alu stalls", n, 1);
    idle(3);
    // R8 load then dependent branch: two cycles
    dec(1,0,0,0,0,0,3,1,1,0); step();
    dec(1,1,3,1,1,1,0,0,0,0); hold_count(n);
    chk(n == 2, "R8", "load->branch stalls", n, 2);
    idle(3);
    // R8 ALU then dependent branch: one cycle
    dec(1,0,0,0,0,0,4,1,0,0); step();
    dec(1,4,0,1,1,1,0,0,0,0); hold_count(n);
    chk(n == 1, "R8", "alu->branch stalls", n, 1);
    idle(3);
    // R4 ALU then ALU user: no stall
    dec(1,0,0,0,0,0,5,1,0,0); step();
    dec(1,5,5,1,1,0,6,1,0,1); hold_count(n);
    chk(n == 0, "R4", "alu->alu stalls", n, 0);
    // R4 load to r0 then reader of r0
    dec(1,0,0,0,0,0,0,1,1,0); step();
    dec(1,0,0,1,1,0,7,1,0,0); hold_count(n);
    chk(n == 0, "R4", "r0 dest stalls", n, 0);
    // R4 load then unused matching source
    dec(1,0,0,0,0,0,8,1,1,0); step();
    dec(1,8,8,0,0,1,9,1,0,0); hold_count(n);
    chk(n == 0, "R4", "unused source stalls", n, 0);
    idle(3);
    // R6 load, gap, branch: one cycle; ALU, gap, branch: none
    dec(1,0,0,0,0,0,10,1,1,0); step();
    dec(1,1,1,1,1,0,11,1,0,0); step();
    dec(1,10,0,1,0,1,0,0,0,0); hold_count(n);
    chk(n == 1, "R6", "load-in-mem branch stalls", n, 1);
    idle(3);
    dec(1,0,0,0,0,0,12,1,0,0); step();
    dec(1,1,1,1,1,0,13,1,0,0); step();
    dec(1,12,0,1,0,1,0,0,0,0); hold_count(n);
    chk(n == 0, "R6", "alu-in-mem branch stalls", n, 0);
    // R4 load, gap, non-branch user: none
    dec(1,0,0,0,0,0,14,1,1,0); step();
    dec(1,1,1,1,1,0,15,1,0,0); step();
    dec(1,0,14,0,1,0,16,1,0,1); hold_count(n);
    chk(n == 0, "R4", "load-in-mem alu stalls", n, 0);
    // dense random traffic, held while stalled (R2 R3 R5 R6 R7 R9 R10)
    for (int i = 0; i < 3000; i++) begin
      if (!last_stall)
        dec($urandom_range(0,7) != 0, $urandom_range(0,3), $urandom_range(0,3),
            $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,3) == 0,
            $urandom_range(0,3), $urandom_range(0,1), $urandom_range(0,2) == 0,
            $urandom_range(0,3) == 0);
      step();
    end
    // R1 mid-run reset clears the slots
    dec(1,0,0,0,0,0,3,1,1,1); step();
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    e_v = 0; e_rd = 0; e_rw = 0; e_ld = 0; e_mw = 0;
    m_v = 0; m_rd = 0; m_rw = 0; m_ld = 0; m_mw = 0;
    reg_tag = "R1";
    dec(0,0,0,0,0,0,0,0,0,0); step();
    summary();
  end
endmodule